// File: doc/BRIEF.md
# External Interrupt Trigger Configuration Unit

This unit conditions a small group of external interrupt pins before they reach an interrupt dispatcher. Each line has its own trigger mode. It can act on an active-high level, an active-low level, a rising edge, a falling edge, or both edges. Each line also has an enable bit. Edge events are held in a per-line latch until software acknowledges them with a write-one clear bit. Every pin passes through a two-flop synchroniser before any detection takes place. Each line drives one masked interrupt output, so the outputs can feed a cascaded internal dispatcher directly.

Software reaches the configuration through a plain register port. A write is a single-cycle strobe with a register index and a 32-bit data word. Read data is combinational and follows the index. Four lines share one 32-bit register. Line n lives in register n/4, in bit slot n mod 4 of every field. There is no data stream at the edge of this block, so all of its pins are plain control and status signals without handshakes.

Top module: `ext_irq_trigger_unit`

## Requirements
- R1: After reset every line is configured as active-low level and is disabled, and every `irq_out` bit is 0. With the default of 6 lines, register 0 reads 0x0000F000 and register 1 reads 0x00003000.
- R2: In each register, the slot of a line (line mod 4) is used in every field as follows: write-one clear in bits [3:0], polarity in bits [7:4], both-edges in bits [11:8], level-select in bits [15:12] and enable in bits [19:16]. Clear bits, bits [31:20], and slots that have no line all read 0. A write updates only the addressed register.
- R3: With level-select=1 and polarity=1, an enabled line's output follows the pin high. A pin change driven before clock edge k shows at the output after edge k+1, because the pin passes two synchroniser flops.
- R4: With level-select=1 and polarity=0, an enabled line's output is the inverse of the synchronised pin.
- R5: With level-select=0, polarity=1 and both-edges=0, a rising synchronised pin sets the line's latch. This becomes visible after edge k+2 for a pin change before edge k. The latch stays set after the pin falls again.
- R6: With level-select=0, polarity=0 and both-edges=0, a falling synchronised pin sets the latch. A rising pin does not set it.
- R7: With level-select=0 and both-edges=1, both rising and falling pin transitions set the latch, whatever the polarity bit holds.
- R8: A line whose enable bit is 0 drives its output low. An edge that arrives while the line is disabled is still latched, and it appears on the output as soon as the line is enabled.
- R9: Writing 1 to a line's clear bit discards its latched event from the next cycle on. Writing 0 to the clear bit leaves the latch unchanged. If a new edge arrives in the same cycle as the clear, the edge wins.
- R10: While a line is in level mode it latches nothing. After a switch from level mode to an edge mode, the output stays 0 until an edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the addressed register |
| cfg_addr | input | ADDR_W (1) | Register index: register n holds lines 4n to 4n+3 |
| cfg_wdata | input | 32 | Write data, using the field layout of R2 |
| cfg_rdata | output | 32 | Read data of the addressed register (combinational) |
| pin_in | input | NUM_LINES (6) | Asynchronous external interrupt pins |
| irq_out | output | NUM_LINES (6) | Masked interrupt output for each line |

## Verification
The embedded properties check several rules on every clock cycle:
- A disabled line never asserts its output.
- A latch only rises after a detected edge.
- A latch holds until it is cleared.
- A clear with no competing edge empties the latch.
- A line in level mode leaves its latch empty.

Some behaviours need the bench's scenarios instead: the exact two-flop and three-flop latencies, the register layout and readback, the polarity choices, and the event recovered when a line is re-enabled. The bench covers these with a cycle-accurate reference model that is driven by constrained random pin activity and register writes, and with directed edge cases.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Lines sharing one configuration register
  localparam int SLOTS = 4;

  // Field base bit positions inside a configuration register
  localparam int F_CLR   = 0;
  localparam int F_SENSE = 4;
  localparam int F_BOTH  = 8;
  localparam int F_LEVEL = 12;
  localparam int F_EN    = 16;

  typedef struct packed {
    logic level_sel;
    logic sense;
    logic both;
    logic enable;
  } line_cfg_t;

  // Unconfigured line: active-low level, disabled
  localparam line_cfg_t CFG_RESET = '{level_sel: 1'b1, sense: 1'b0, both: 1'b0, enable: 1'b0};

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int ADDR_W    = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  output line_cfg_t [NUM_LINES-1:0]     cfg,
  output logic [NUM_LINES-1:0]          clr_pulse,
  output logic [31:0]                   rdata
);

  line_cfg_t [NUM_LINES-1:0] cfg_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [ADDR_W-1:0] MY_REG = ADDR_W'(i / SLOTS);
    localparam int                SLOT   = i % SLOTS;
    logic hit;

    assign hit = wr_en && (addr == MY_REG);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= CFG_RESET;
      end else if (hit) begin
        cfg_q[i].level_sel <= wdata[F_LEVEL + SLOT];
        cfg_q[i].sense     <= wdata[F_SENSE + SLOT];
        cfg_q[i].both      <= wdata[F_BOTH  + SLOT];
        cfg_q[i].enable    <= wdata[F_EN    + SLOT];
      end
    end

    // Write-one clear acts as a pulse and is never stored
    assign clr_pulse[i] = hit && wdata[F_CLR + SLOT];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (addr == ADDR_W'(i / SLOTS)) begin
        rdata[F_SENSE + (i % SLOTS)] = cfg_q[i].sense;
        rdata[F_BOTH  + (i % SLOTS)] = cfg_q[i].both;
        rdata[F_LEVEL + (i % SLOTS)] = cfg_q[i].level_sel;
        rdata[F_EN    + (i % SLOTS)] = cfg_q[i].enable;
      end
    end
  end

  assign cfg = cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cfg_t cfg,
  input  logic      pin_s,
  input  logic      clr_pulse,
  output logic      irq
);

  logic pin_d;
  logic latch_q;
  logic rise;
  logic fall;
  logic edge_hit;
  logic level_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= 1'b0;
    else        pin_d <= pin_s;
  end

  assign rise = pin_s & ~pin_d;
  assign fall = ~pin_s & pin_d;

  always_comb begin
    if (cfg.both)       edge_hit = rise | fall;
    else if (cfg.sense) edge_hit = rise;
    else                edge_hit = fall;
  end

  // A new edge takes priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              latch_q <= 1'b0;
    else if (cfg.level_sel)  latch_q <= 1'b0;
    else if (edge_hit)       latch_q <= 1'b1;
    else if (clr_pulse)      latch_q <= 1'b0;
  end

  assign level_act = cfg.sense ? pin_s : ~pin_s;
  assign irq       = cfg.enable & (cfg.level_sel ? level_act : latch_q);

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !cfg.level_sel && !clr_pulse) |=> latch_q); // R5
  AST_LATCH_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(edge_hit)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !edge_hit) |=> !latch_q); // R9
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.level_sel |=> !latch_q); // R10

endmodule

// File: rtl/ext_irq_trigger_unit.sv
module ext_irq_trigger_unit
  import ext_irq_pkg::*;
#(
  parameter int  NUM_LINES = 6,
  localparam int NUM_REGS  = (NUM_LINES + SLOTS - 1) / SLOTS,
  localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] irq_out
);

  line_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0]      clr_pulse;
  logic [NUM_LINES-1:0]      pin_s;

  ext_irq_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_s)
  );

  ext_irq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .cfg       (cfg),
    .clr_pulse (clr_pulse),
    .rdata     (cfg_rdata)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    ext_irq_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg[i]),
      .pin_s     (pin_s[i]),
      .clr_pulse (clr_pulse[i]),
      .irq       (irq_out[i])
    );

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[i].enable |-> !irq_out[i]); // R8
  end

endmodule

// File: tb/test_ext_irq_trigger_unit.sv
`timescale 1ns/1ps
module test_ext_irq_trigger_unit;

  localparam int N = 6;
  localparam int A = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [A-1:0]  cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic [N-1:0]  pin_in;
  logic [N-1:0]  irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ext_irq_trigger_unit #(.NUM_LINES(N)) i_ext_irq_trigger_unit (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  // Reference state
  logic [N-1:0] m_s1, m_s2, m_sd, m_latch, m_lvl, m_sense, m_both, m_en;

  function automatic logic [N-1:0] exp_irq();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = m_en[i] & (m_lvl[i] ? (m_sense[i] ? m_s2[i] : ~m_s2[i]) : m_latch[i]);
    return r;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [A-1:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < N; i++) begin
      if (a == A'(i / 4)) begin
        r[4 + i % 4]  = m_sense[i];
        r[8 + i % 4]  = m_both[i];
        r[12 + i % 4] = m_lvl[i];
        r[16 + i % 4] = m_en[i];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, advance model across posedge, compare at next negedge
  task automatic step(input logic wr, input logic [A-1:0] a, input logic [31:0] d, input string tag);
    logic [N-1:0] n_latch;
    cfg_wr_en = wr; cfg_addr = a; cfg_wdata = d;
    for (int i = 0; i < N; i++) begin
      logic rise, fall, hit, clr;
      rise = m_s2[i] & ~m_sd[i];
      fall = ~m_s2[i] & m_sd[i];
      hit  = m_both[i] ? (rise | fall) : (m_sense[i] ? rise : fall);
      clr  = wr && (a == A'(i / 4)) && d[i % 4];
      n_latch[i] = m_lvl[i] ? 1'b0 : (hit ? 1'b1 : (clr ? 1'b0 : m_latch[i]));
    end
    @(posedge clk);
    m_latch = n_latch;
    m_sd = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    if (wr) begin
      for (int i = 0; i < N; i++) begin
        if (a == A'(i / 4)) begin
          m_sense[i] = d[4 + i % 4];
          m_both[i]  = d[8 + i % 4];
          m_lvl[i]   = d[12 + i % 4];
          m_en[i]    = d[16 + i % 4];
        end
      end
    end
    @(negedge clk);
    cfg_wr_en = 1'b0;
    chk(tag, 32'(irq_out), 32'(exp_irq()));
    chk("R2", cfg_rdata, exp_rdata(cfg_addr));
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, cfg_addr, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0; pin_in = '0;
    m_s1 = '0; m_s2 = '0; m_sd = '0; m_latch = '0;
    m_lvl = '1; m_sense = '0; m_both = '0; m_en = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset values
    chk("R1", 32'(irq_out), 32'h0);
    chk("R1", cfg_rdata, 32'h0000F000);
    cfg_addr = 1'b1; #1;
    chk("R1", cfg_rdata, 32'h00003000);
    cfg_addr = 1'b0;
    @(negedge clk);

    // R2 clear bits and absent slots read zero
    step(1'b1, 1'b1, 32'hFFFF_FFFF, "R2");
    chk("R2", cfg_rdata, 32'h00033330);
    step(1'b1, 1'b1, 32'h0, "R2");

    // R3 active-high level on line 1, two-flop latency
    step(1'b1, 1'b0, 32'h00022020, "R3");
    pin_in[1] = 1'b1;
    step(1'b0, 1'b0, 32'h0, "R3");
    chk("R3", 32'(irq_out[1]), 32'h0);
    step(1'b0, 1'b0, 32'h0, "R3");
    chk("R3", 32'(irq_out[1]), 32'h1);
    pin_in[1] = 1'b0;
    idle(3, "R3");

    // R4 active-low level on line 4
    step(1'b1, 1'b1, 32'h00011000, "R4");
    chk("R4", 32'(irq_out[4]), 32'h1);
    pin_in[4] = 1'b1;
    idle(3, "R4");
    chk("R4", 32'(irq_out[4]), 32'h0);

    // R5 rising edge on line 0, three-flop latency, held after pin falls
    step(1'b1, 1'b0, 32'h00010010, "R5");
    pin_in[0] = 1'b1;
    step(1'b0, 1'b0, 32'h0, "R5");
    step(1'b0, 1'b0, 32'h0, "R5");
    chk("R5", 32'(irq_out[0]), 32'h0);
    step(1'b0, 1'b0, 32'h0, "R5");
    chk("R5", 32'(irq_out[0]), 32'h1);
    pin_in[0] = 1'b0;
    idle(4, "R5");
    chk("R5", 32'(irq_out[0]), 32'h1);

    // R9 clear-bit 0 keeps, clear-bit 1 drops
    step(1'b1, 1'b0, 32'h00010010, "R9");
    chk("R9", 32'(irq_out[0]), 32'h1);
    step(1'b1, 1'b0, 32'h00010011, "R9");
    chk("R9", 32'(irq_out[0]), 32'h0);

    // R6 falling edge on line 0
    step(1'b1, 1'b0, 32'h00010000, "R6");
    pin_in[0] = 1'b1; idle(4, "R6");
    chk("R6", 32'(irq_out[0]), 32'h0);
    pin_in[0] = 1'b0; idle(4, "R6");
    chk("R6", 32'(irq_out[0]), 32'h1);
    step(1'b1, 1'b0, 32'h00010001, "R9");

    // R7 both edges, polarity set and clear
    step(1'b1, 1'b0, 32'h00010110, "R7");
    pin_in[0] = 1'b1; idle(4, "R7");
    chk("R7", 32'(irq_out[0]), 32'h1);
    step(1'b1, 1'b0, 32'h00010101, "R7");
    chk("R7", 32'(irq_out[0]), 32'h0);
    pin_in[0] = 1'b0; idle(4, "R7");
    chk("R7", 32'(irq_out[0]), 32'h1);
    step(1'b1, 1'b0, 32'h00010101, "R9");

    // R8 edge latched while disabled, visible on enable
    step(1'b1, 1'b0, 32'h00000010, "R8");
    pin_in[0] = 1'b1; idle(4, "R8");
    chk("R8", 32'(irq_out[0]), 32'h0);
    step(1'b1, 1'b0, 32'h00010010, "R8");
    chk("R8", 32'(irq_out[0]), 32'h1);

    // R9 edge and clear in same cycle: edge wins
    pin_in[0] = 1'b0; idle(3, "R9");
    step(1'b1, 1'b0, 32'h00010011, "R9");
    pin_in[0] = 1'b1;
    step(1'b0, 1'b0, 32'h0, "R9");
    step(1'b0, 1'b0, 32'h0, "R9");
    step(1'b1, 1'b0, 32'h00010011, "R9");
    chk("R9", 32'(irq_out[0]), 32'h1);

    // R10 level mode latches nothing
    step(1'b1, 1'b0, 32'h00001000, "R10");
    pin_in[0] = 1'b0; idle(3, "R10");
    pin_in[0] = 1'b1; idle(3, "R10");
    step(1'b1, 1'b0, 32'h00010010, "R10");
    chk("R10", 32'(irq_out[0]), 32'h0);

    // Constrained random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 5) == 0) pin_in[$urandom_range(0, N - 1)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0)
        step(1'b1, A'($urandom_range(0, 1)), $urandom & 32'h000F_FFFF, "R7");
      else
        step(1'b0, A'($urandom_range(0, 1)), 32'h0, "R6");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule